// File: doc/BRIEF.md
# Sampled Cache Miss Address Monitor

This block is a performance-monitor unit that sits next to a data cache. It sees one strobe for each cache miss. With that strobe come the missing address and, when the refill pushes out a valid line, that line's address. A software-loaded down-counter counts the misses. When it expires, the unit stores the exact miss address and the victim address in hardware and raises a sticky interrupt. Software therefore never has to rebuild the address from program state, which may already have moved on.

Each time the counter expires it reloads from a base period plus a pseudo-random jitter. The jitter is the state of a 16-bit LFSR, masked to a programmable set of low bits, so successive sample intervals differ and the sampling cannot lock onto a periodic access pattern. While the interrupt is pending, the captured values are frozen and counting goes on. Another expiry in that time is recorded in a lost-sample flag. Software reads the captures over a small register port and clears the interrupt with a write-1-to-clear register.

Top module: `cmiss_sampler`

## Requirements
- R1: After reset, CTRL (offset 0) reads 0, PERIOD (offset 1) and COUNT (offset 3) read 50000, JMASK (offset 2) reads 0, STATUS (offset 6) reads 0 and `irq` is low.
- R2: While CTRL bit 0 (enable) is 1, each miss strobe lowers COUNT by one when COUNT is above 1. While enable is 0, miss strobes leave COUNT, STATUS and the captures unchanged.
- R3: A miss strobe with enable set and COUNT at 1 or 0 is the sampled miss. It reloads COUNT with PERIOD + (LFSR & JMASK) and sets the pending flag, which is STATUS bit 0 and drives `irq`.
- R4: On a sampled miss with no interrupt pending, MADDR (offset 4) captures that miss's address.
- R5: On the same event, VADDR (offset 5) captures the victim address and STATUS bit 2 captures the victim-valid input. The bit is 0 when the refill used an empty way.
- R6: While the interrupt is pending, MADDR, VADDR and STATUS bit 2 hold their values. Counting and reloading continue.
- R7: A sampled miss that occurs while the interrupt is pending sets the lost flag, STATUS bit 1.
- R8: Writing ICLR (offset 7) with bit 0 set clears the pending and lost flags. Writing it with bit 0 clear changes nothing.
- R9: The jitter source is a right-shifting Galois LFSR: taps 0xB400, seed 0xACE1, one step per sampled miss, using the pre-step value. With JMASK 0 every reload equals PERIOD.
- R10: A write to COUNT presets the down-counter, so the Nth following enabled miss is sampled.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| miss_stb | input | 1 | One-cycle strobe per cache miss |
| miss_addr | input | AW | Data address of the miss |
| victim_vld | input | 1 | The miss displaced a valid line |
| victim_addr | input | AW | Address of the displaced line |
| reg_wr | input | 1 | Register write strobe |
| reg_addr | input | 3 | Register offset |
| reg_wdata | input | DW | Register write data |
| reg_rdata | output | DW | Register read data, combinational from reg_addr |
| irq | output | 1 | Sticky sample interrupt |

## Verification
Assertions check on every cycle that the counter steps down by exactly one per enabled miss and stands still otherwise. They also check that a preset lands, that an expiry leaves the interrupt pending, that the captures are frozen while it is pending, and that a second expiry sets the lost flag. They further check that a clear drops both flags and that the LFSR never reaches zero and moves on each expiry. Only the bench scenarios can show the following: the reload value matches the jittered base period for the exact LFSR sequence; the correct miss is the one sampled after a preset; and long random traffic with interleaved clears keeps count, captures and flags in step with an independent model.

// File: rtl/miss_mon_pkg.sv
// Package: shared register offsets, status bit positions and LFSR constants
// for the sampled cache miss monitor. Assumes a 3-bit register offset space.
package miss_mon_pkg;
    localparam logic [2:0] RA_CTRL   = 3'd0;
    localparam logic [2:0] RA_PERIOD = 3'd1;
    localparam logic [2:0] RA_JMASK  = 3'd2;
    localparam logic [2:0] RA_COUNT  = 3'd3;
    localparam logic [2:0] RA_MADDR  = 3'd4;
    localparam logic [2:0] RA_VADDR  = 3'd5;
    localparam logic [2:0] RA_STATUS = 3'd6;
    localparam logic [2:0] RA_ICLR   = 3'd7;

    localparam int ST_PEND  = 0;
    localparam int ST_LOST  = 1;
    localparam int ST_VVLD  = 2;

    localparam int          JIT_W    = 16;
    localparam logic [15:0] JIT_TAPS = 16'hB400;
    localparam logic [15:0] JIT_SEED = 16'hACE1;
endpackage

// File: rtl/miss_jitter_lfsr.sv
// Module: Galois LFSR that supplies the sampling jitter. It advances one step
// each time `step` is high. Assumes a nonzero seed; the state never reaches zero.
module miss_jitter_lfsr #(
    parameter int          LW   = 16,
    parameter logic [LW-1:0] TAPS = 16'hB400,
    parameter logic [LW-1:0] SEED = 16'hACE1
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          step,
    output logic [LW-1:0] state
);
    // Shift right and fold in the taps when the bit shifted out is 1.
    always_ff @(posedge clk) begin
        if (!rst_n)
            state <= SEED;
        else if (step)
            state <= (state >> 1) ^ (state[0] ? TAPS : '0);
    end

    // R9: the state never collapses to zero
    a_r9_nonzero: assert property (@(posedge clk) disable iff (!rst_n)
        state != '0);
    // R9: each step moves to a new state
    a_r9_steps: assert property (@(posedge clk) disable iff (!rst_n)
        step |=> state != $past(state));
endmodule

// File: rtl/miss_countdown.sv
// Module: down-counter of enabled misses. It flags the sampled miss when a
// miss arrives at a count of 1 or 0, then reloads from base plus jitter.
// A software preset (load) takes priority over counting in the same cycle.
module miss_countdown #(
    parameter int            CW        = 32,
    parameter int            LW        = 16,
    parameter logic [CW-1:0] RST_COUNT = 50000
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          enable,
    input  logic          miss,
    input  logic          load,
    input  logic [CW-1:0] load_val,
    input  logic [CW-1:0] base,
    input  logic [LW-1:0] jitter,
    output logic [CW-1:0] count,
    output logic          expire
);
    logic counting;

    // Decode this cycle's counting event and whether it is the sampled miss.
    always_comb begin
        counting = enable && miss;
        expire   = counting && (count <= CW'(1));
    end

    // Preset, reload on expiry, or step down by one.
    always_ff @(posedge clk) begin
        if (!rst_n)
            count <= RST_COUNT;
        else if (load)
            count <= load_val;
        else if (expire)
            count <= base + CW'(jitter);
        else if (counting)
            count <= count - CW'(1);
    end

    // R2: an enabled miss above 1 lowers the count by exactly one
    a_r2_decrement: assert property (@(posedge clk) disable iff (!rst_n)
        (enable && miss && count > CW'(1) && !load) |=> count == $past(count) - CW'(1));
    // R2: no enabled miss, no preset -> count stands still
    a_r2_idle: assert property (@(posedge clk) disable iff (!rst_n)
        (!(enable && miss) && !load) |=> $stable(count));
    // R10: a preset lands in the next cycle
    a_r10_preset: assert property (@(posedge clk) disable iff (!rst_n)
        load |=> count == $past(load_val));
endmodule

// File: rtl/miss_capture.sv
// Module: sample capture registers with sticky pending and lost flags.
// Captures only when no interrupt is pending (or it is being cleared in the
// same cycle); an expiry while pending sets the lost flag instead.
module miss_capture #(
    parameter int AW = 32
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          expire,
    input  logic          clr,
    input  logic [AW-1:0] miss_addr,
    input  logic          vic_vld,
    input  logic [AW-1:0] vic_addr,
    output logic [AW-1:0] samp_addr,
    output logic [AW-1:0] samp_vaddr,
    output logic          samp_vvld,
    output logic          pending,
    output logic          lost
);
    logic take;

    // A sample is taken when the slot is free or being freed this cycle.
    always_comb take = expire && (!pending || clr);

    // Latch the miss and victim addresses of the sampled miss.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            samp_addr  <= '0;
            samp_vaddr <= '0;
            samp_vvld  <= 1'b0;
        end else if (take) begin
            samp_addr  <= miss_addr;
            samp_vaddr <= vic_addr;
            samp_vvld  <= vic_vld;
        end
    end

    // Maintain the sticky interrupt and the lost-sample flag.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            pending <= 1'b0;
            lost    <= 1'b0;
        end else begin
            if (take)
                pending <= 1'b1;
            else if (clr)
                pending <= 1'b0;
            if (clr)
                lost <= 1'b0;
            else if (expire && pending)
                lost <= 1'b1;
        end
    end

    // R3: an expiry always leaves the interrupt pending
    a_r3_pend_set: assert property (@(posedge clk) disable iff (!rst_n)
        expire |=> pending);
    // R4: a free-slot expiry captures that miss's address
    a_r4_capture: assert property (@(posedge clk) disable iff (!rst_n)
        (expire && !pending) |=> samp_addr == $past(miss_addr));
    // R6: captures frozen while pending and not cleared
    a_r6_frozen: assert property (@(posedge clk) disable iff (!rst_n)
        (pending && !clr) |=> ($stable(samp_addr) && $stable(samp_vaddr) && $stable(samp_vvld)));
    // R7: an expiry while pending sets the lost flag
    a_r7_lost: assert property (@(posedge clk) disable iff (!rst_n)
        (pending && expire && !clr) |=> lost);
    // R8: a clear with no expiry drops both flags
    a_r8_clear: assert property (@(posedge clk) disable iff (!rst_n)
        (clr && !expire) |=> (!pending && !lost));
endmodule

// File: rtl/miss_regs.sv
// Module: register port. It holds the enable, base period and jitter mask,
// decodes the preset and clear strobes, and muxes the read data.
// Assumes AW, CW and LW are no wider than DW.
module miss_regs
    import miss_mon_pkg::*;
#(
    parameter int            DW         = 32,
    parameter int            AW         = 32,
    parameter int            CW         = 32,
    parameter int            LW         = 16,
    parameter logic [CW-1:0] DEF_PERIOD = 50000
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          reg_wr,
    input  logic [2:0]    reg_addr,
    input  logic [DW-1:0] reg_wdata,
    output logic [DW-1:0] reg_rdata,
    output logic          enable,
    output logic [CW-1:0] base,
    output logic [LW-1:0] jmask,
    output logic          load,
    output logic [CW-1:0] load_val,
    output logic          clr,
    input  logic [CW-1:0] count,
    input  logic [AW-1:0] samp_addr,
    input  logic [AW-1:0] samp_vaddr,
    input  logic          samp_vvld,
    input  logic          pending,
    input  logic          lost
);
    // Decode the strobes that act on other submodules.
    always_comb begin
        load     = reg_wr && (reg_addr == RA_COUNT);
        load_val = CW'(reg_wdata);
        clr      = reg_wr && (reg_addr == RA_ICLR) && reg_wdata[0];
    end

    // Hold the software-written configuration.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            enable <= 1'b0;
            base   <= DEF_PERIOD;
            jmask  <= '0;
        end else if (reg_wr) begin
            case (reg_addr)
                RA_CTRL:   enable <= reg_wdata[0];
                RA_PERIOD: base   <= CW'(reg_wdata);
                RA_JMASK:  jmask  <= LW'(reg_wdata);
                default:   ;
            endcase
        end
    end

    // Select the read data for the addressed register.
    always_comb begin
        reg_rdata = '0;
        case (reg_addr)
            RA_CTRL:   reg_rdata = DW'(enable);
            RA_PERIOD: reg_rdata = DW'(base);
            RA_JMASK:  reg_rdata = DW'(jmask);
            RA_COUNT:  reg_rdata = DW'(count);
            RA_MADDR:  reg_rdata = DW'(samp_addr);
            RA_VADDR:  reg_rdata = DW'(samp_vaddr);
            RA_STATUS: begin
                reg_rdata[ST_PEND] = pending;
                reg_rdata[ST_LOST] = lost;
                reg_rdata[ST_VVLD] = samp_vvld;
            end
            default:   reg_rdata = '0;
        endcase
    end
endmodule

// File: rtl/cmiss_sampler.sv
// Module: top of the sampled cache miss monitor. It counts misses, samples
// the miss and victim addresses at expiry, reloads the counter with a
// jittered period and raises a sticky interrupt.
// Assumes the victim information arrives in the same cycle as the miss strobe.
module cmiss_sampler
    import miss_mon_pkg::*;
#(
    parameter int AW         = 32,
    parameter int DW         = 32,
    parameter int CW         = 32,
    parameter int DEF_PERIOD = 50000
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          miss_stb,
    input  logic [AW-1:0] miss_addr,
    input  logic          victim_vld,
    input  logic [AW-1:0] victim_addr,
    input  logic          reg_wr,
    input  logic [2:0]    reg_addr,
    input  logic [DW-1:0] reg_wdata,
    output logic [DW-1:0] reg_rdata,
    output logic          irq
);
    localparam int            LW      = JIT_W;
    localparam logic [CW-1:0] RST_CNT = CW'(DEF_PERIOD);

    logic          enable, load, clr, expire, pending, lost, samp_vvld;
    logic [CW-1:0] base, load_val, count;
    logic [LW-1:0] jmask, lfsr, jitter;
    logic [AW-1:0] samp_addr, samp_vaddr;

    // Mask the LFSR state down to the programmed jitter bits.
    always_comb jitter = lfsr & jmask;

    // Drive the interrupt straight from the pending flag.
    always_comb irq = pending;

    miss_regs #(.DW(DW), .AW(AW), .CW(CW), .LW(LW), .DEF_PERIOD(RST_CNT)) u_regs (
        .clk(clk), .rst_n(rst_n), .reg_wr(reg_wr), .reg_addr(reg_addr),
        .reg_wdata(reg_wdata), .reg_rdata(reg_rdata), .enable(enable),
        .base(base), .jmask(jmask), .load(load), .load_val(load_val), .clr(clr),
        .count(count), .samp_addr(samp_addr), .samp_vaddr(samp_vaddr),
        .samp_vvld(samp_vvld), .pending(pending), .lost(lost));

    miss_jitter_lfsr #(.LW(LW), .TAPS(JIT_TAPS), .SEED(JIT_SEED)) u_lfsr (
        .clk(clk), .rst_n(rst_n), .step(expire), .state(lfsr));

    miss_countdown #(.CW(CW), .LW(LW), .RST_COUNT(RST_CNT)) u_count (
        .clk(clk), .rst_n(rst_n), .enable(enable), .miss(miss_stb), .load(load),
        .load_val(load_val), .base(base), .jitter(jitter), .count(count),
        .expire(expire));

    miss_capture #(.AW(AW)) u_cap (
        .clk(clk), .rst_n(rst_n), .expire(expire), .clr(clr),
        .miss_addr(miss_addr), .vic_vld(victim_vld), .vic_addr(victim_addr),
        .samp_addr(samp_addr), .samp_vaddr(samp_vaddr), .samp_vvld(samp_vvld),
        .pending(pending), .lost(lost));
endmodule

// File: tb/cmiss_sampler_test.sv
`timescale 1ns/1ps
// Bench: directed corner cases, then seeded random miss traffic, all compared
// against a bench-side model of the counter, LFSR, captures and flags.
module cmiss_sampler_test;
    localparam logic [2:0] O_CTRL = 0, O_PER = 1, O_JM = 2, O_CNT = 3,
                           O_MA = 4, O_VA = 5, O_ST = 6, O_CLR = 7;

    logic        clk = 0, rst_n = 0;
    logic        miss_stb = 0, victim_vld = 0, reg_wr = 0;
    logic [31:0] miss_addr = 0, victim_addr = 0, reg_wdata = 0, reg_rdata;
    logic [2:0]  reg_addr = 0;
    logic        irq;

    int nchk = 0, nfail = 0;
    bit done = 0;

    // independent model state
    bit          m_en = 0, m_pend = 0, m_lost = 0, m_vv = 0;
    logic [31:0] m_base = 50000, m_cnt = 50000, m_ma = 0, m_va = 0;
    logic [15:0] m_mask = 0, m_lfsr = 16'hACE1;

    always #4 clk = ~clk;

    cmiss_sampler uut (.clk(clk), .rst_n(rst_n), .miss_stb(miss_stb),
        .miss_addr(miss_addr), .victim_vld(victim_vld), .victim_addr(victim_addr),
        .reg_wr(reg_wr), .reg_addr(reg_addr), .reg_wdata(reg_wdata),
        .reg_rdata(reg_rdata), .irq(irq));

    function automatic logic [15:0] lfsr_next(input logic [15:0] s);
        return (s >> 1) ^ (s[0] ? 16'hB400 : 16'h0);
    endfunction

    function automatic logic [31:0] status_exp();
        return {29'd0, m_vv, m_lost, m_pend};
    endfunction

    task automatic chk(input string req, input string what,
                       input logic [31:0] act, input logic [31:0] exp);
        nchk++;
        if (act !== exp) begin
            nfail++;
            $display("FAIL %s %s: actual %h expected %h", req, what, act, exp);
        end
    endtask

    task automatic rd(input logic [2:0] a, output logic [31:0] d);
        reg_addr = a;
        #1 d = reg_rdata;
    endtask

    task automatic wr(input logic [2:0] a, input logic [31:0] d);
        @(negedge clk);
        reg_wr = 1; reg_addr = a; reg_wdata = d;
        @(negedge clk);
        reg_wr = 0;
    endtask

    // model update for one miss strobe
    task automatic model_miss(input logic [31:0] a, input bit vv, input logic [31:0] va);
        if (!m_en) return;
        if (m_cnt <= 1) begin
            m_cnt  = m_base + {16'd0, m_lfsr & m_mask};
            m_lfsr = lfsr_next(m_lfsr);
            if (m_pend) m_lost = 1;
            else begin m_pend = 1; m_ma = a; m_va = va; m_vv = vv; end
        end else m_cnt = m_cnt - 1;
    endtask

    task automatic miss(input logic [31:0] a, input bit vv, input logic [31:0] va);
        @(negedge clk);
        miss_stb = 1; miss_addr = a; victim_vld = vv; victim_addr = va;
        @(negedge clk);
        miss_stb = 0;
        model_miss(a, vv, va);
    endtask

    task automatic summary();
        $display("End of test - %0d assertions evaluated, %0d failures", nchk, nfail);
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        if (!done) begin
            nfail++;
            $display("FAIL watchdog: actual hung expected finished");
            summary();
            $finish;
        end
    end

    initial begin
        logic [31:0] d, first_reload;
        bit varied;
        void'($urandom(32'd20240611));
        repeat (3) @(negedge clk);
        rst_n = 1;
        @(negedge clk);

        // R1 reset state
        rd(O_CTRL, d); chk("R1", "CTRL", d, 0);
        rd(O_PER, d);  chk("R1", "PERIOD", d, 50000);
        rd(O_CNT, d);  chk("R1", "COUNT", d, 50000);
        rd(O_JM, d);   chk("R1", "JMASK", d, 0);
        rd(O_ST, d);   chk("R1", "STATUS", d, 0);
        chk("R1", "irq", {31'd0, irq}, 0);

        // R2 disabled misses are ignored
        for (int i = 0; i < 3; i++) miss(32'h100 + i, 1, 32'h900);
        rd(O_CNT, d); chk("R2", "COUNT while disabled", d, 50000);
        rd(O_ST, d);  chk("R2", "STATUS while disabled", d, 0);

        // R10 preset, R9 fixed period with zero mask
        wr(O_PER, 4); m_base = 4;
        wr(O_CTRL, 1); m_en = 1;
        wr(O_CNT, 3); m_cnt = 3;
        rd(O_CNT, d); chk("R10", "COUNT preset", d, 3);
        miss(32'hA000_0040, 1, 32'hB000_0080);
        miss(32'hA000_0044, 1, 32'hB000_0084);
        rd(O_CNT, d); chk("R2", "COUNT after two misses", d, 1);
        chk("R10", "irq before Nth miss", {31'd0, irq}, 0);
        miss(32'hCAFE_0100, 1, 32'hBEEF_0200);
        chk("R3", "irq at sampled miss", {31'd0, irq}, 1);
        rd(O_CNT, d); chk("R9", "reload with zero mask", d, 4);
        rd(O_MA, d);  chk("R4", "MADDR", d, 32'hCAFE_0100);
        rd(O_VA, d);  chk("R5", "VADDR", d, 32'hBEEF_0200);
        rd(O_ST, d);  chk("R5", "STATUS victim valid", d, 32'h5);

        // R6 hold while pending, R7 lost flag
        for (int i = 0; i < 3; i++) miss(32'h7700 + i, 0, 32'h1);
        rd(O_CNT, d); chk("R6", "counting while pending", d, 1);
        rd(O_MA, d);  chk("R6", "MADDR held", d, 32'hCAFE_0100);
        miss(32'h7777, 0, 32'h2);
        rd(O_ST, d);  chk("R7", "STATUS lost", d, 32'h7);
        rd(O_VA, d);  chk("R6", "VADDR held", d, 32'hBEEF_0200);

        // R8 clear
        wr(O_CLR, 0);
        rd(O_ST, d); chk("R8", "ICLR bit0=0 ignored", d, 32'h7);
        wr(O_CLR, 1); m_pend = 0; m_lost = 0;
        rd(O_ST, d); chk("R8", "ICLR clears flags", d, 32'h4);
        chk("R8", "irq after clear", {31'd0, irq}, 0);

        // R5 victim invalid at sampled miss
        for (int i = 0; i < 4; i++) miss(32'h5500 + i, 0, 32'hDEAD);
        rd(O_ST, d); chk("R5", "victim invalid", d, status_exp());
        rd(O_MA, d); chk("R4", "MADDR second sample", d, 32'h5503);
        wr(O_CLR, 1); m_pend = 0; m_lost = 0;

        // R9 jittered reloads follow the LFSR
        wr(O_JM, 32'hF); m_mask = 16'hF;
        wr(O_PER, 2); m_base = 2;
        wr(O_CNT, 1); m_cnt = 1;
        varied = 0; first_reload = 0;
        for (int k = 0; k < 6; k++) begin
            do miss($urandom, 1, $urandom); while (m_cnt != m_base + {16'd0, 16'd0} && 0);
            rd(O_CNT, d); chk("R9", "jittered reload", d, m_cnt);
            if (k == 0) first_reload = d; else if (d != first_reload) varied = 1;
            wr(O_CNT, 1); m_cnt = 1;
        end
        chk("R9", "reload values vary", {31'd0, varied}, 1);
        wr(O_CLR, 1); m_pend = 0; m_lost = 0;

        // random traffic, R2..R8 against the model
        wr(O_PER, 3); m_base = 3;
        wr(O_JM, 3);  m_mask = 3;
        for (int i = 0; i < 1500; i++) begin
            if ($urandom % 2) miss($urandom, bit'($urandom % 2), $urandom);
            else @(negedge clk);
            chk("R3", "irq random", {31'd0, irq}, {31'd0, m_pend});
            if (i % 16 == 0) begin
                rd(O_CNT, d); chk("R2", "COUNT random", d, m_cnt);
                rd(O_MA, d);  chk("R4", "MADDR random", d, m_ma);
                rd(O_VA, d);  chk("R5", "VADDR random", d, m_va);
                rd(O_ST, d);  chk("R7", "STATUS random", d, status_exp());
            end
            if (m_pend && ($urandom % 4 == 0)) begin
                wr(O_CLR, 1); m_pend = 0; m_lost = 0;
            end
        end

        // R2 disable again: misses ignored
        wr(O_CTRL, 0); m_en = 0;
        rd(O_CNT, d);
        first_reload = d;
        for (int i = 0; i < 5; i++) miss(32'h42, 1, 32'h43);
        rd(O_CNT, d); chk("R2", "COUNT frozen after disable", d, first_reload);

        done = 1;
        summary();
        $finish;
    end
endmodule